// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits between a shared interrupt source layer and one processor. It keeps that processor's interrupt context: the current priority the processor is running at, the number and priority of the single source currently offered to it, and the priority of an inter-processor interrupt (IPI) that competes with real sources as a pseudo-source. It drives one level interrupt line that is high exactly while a source is latched.

The source layer offers requests (source number, priority) on a valid/ready port. The controller latches a request that beats both the current priority and any latched source; otherwise it sends it back as a reject. A winning request that displaces a latched source rejects that source in the same cycle. The processor uses a four-operation valid/ready port: set current priority, set IPI priority, accept (returns the acknowledge word and clears the offer) and end-of-interrupt. Reject, end-of-interrupt and resend notices go back to the source layer as one-cycle pulses, at most one per cycle.

Two states drive the control: `ST_IDLE` takes one operation or one delivery per cycle; `ST_RESEND` emits the resend notice that follows an end-of-interrupt when nothing is latched. Transitions: `ST_IDLE -> ST_RESEND` on an end-of-interrupt with no latched source; `ST_RESEND -> ST_IDLE` always after one cycle; otherwise `ST_IDLE` stays.

Top module: `ipc_core`

## Requirements
- R1: After reset the acknowledge word is 0, the IPI priority is 0xFF, the pending priority is 0xFF, the interrupt line is low and no notice is valid. Priority 0xFF is least favored; lower values win.
- R2: A delivery whose priority is greater than or equal to the current priority, or that meets a latched source (source field nonzero) with pending priority less than or equal to its own, is answered the next cycle with a reject notice carrying its source, and the acknowledge word is unchanged.
- R3: A winning delivery latches its source into bits 23:0 and its priority as pending priority and raises the line; a source it displaces gets a reject notice in that cycle. The line is high exactly while bits 23:0 are nonzero.
- R4: Accept (op code 2) returns the acknowledge word on the read port one cycle later, lowers the line, copies the pending priority into bits 31:24, clears bits 23:0 and sets the pending priority to 0xFF.
- R5: Set current priority (op code 0, value in write bits 7:0) to a value below the old one clears a latched source whose pending priority is not below the new value: the line drops and that source is rejected. A more favored latched source stays.
- R6: Set current priority to a value at or above the old one with nothing latched emits a resend notice; if the IPI priority is below the new current priority the IPI source (parameter, default 2) is latched with the IPI priority.
- R7: Set IPI priority (op code 1, value in write bits 7:0) stores the value; if it is below the current priority and no latched source has pending priority less than or equal to it, the latched source is rejected and the IPI source is latched with that priority.
- R8: End-of-interrupt (op code 3) loads bits 31:24 of the written word as current priority and emits an EOI notice with bits 23:0; if no source was latched it also runs the IPI check against the new priority and emits a resend notice in the following cycle.
- R9: Notices are one-cycle pulses with a 2-bit kind (1 reject, 2 EOI, 3 resend) and a 24-bit source field; a valid notice never has kind 0.
- R10: A processor operation has precedence: delivery ready is low while an operation is offered, and both ports are not ready in the resend cycle.
- R11: The acknowledge word and IPI priority are continuously visible and reading them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation offered |
| op_code | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| op_wdata | input | 32 | Operation write value |
| op_ready | output | 1 | Operation taken this cycle when high |
| rd_valid | output | 1 | Accept result valid (one cycle) |
| rd_data | output | 32 | Acknowledge word returned by accept |
| dlv_valid | input | 1 | Delivery request offered |
| dlv_src | input | 24 | Delivery source number (nonzero) |
| dlv_prio | input | 8 | Delivery priority |
| dlv_ready | output | 1 | Delivery taken this cycle when high |
| ntf_valid | output | 1 | Notice valid |
| ntf_kind | output | 2 | Notice kind: 1 reject, 2 EOI, 3 resend |
| ntf_src | output | 24 | Notice source number |
| irq_out | output | 1 | Interrupt line to the processor |
| ack_word | output | 32 | Current priority (31:24) and latched source (23:0) |
| ipi_prio | output | 8 | Current IPI priority |

## Verification
The processor operation port and the delivery port can both be offered in the same cycle. The bench raises both together, once with a harmless IPI-priority write, and judges that delivery ready is low in that cycle, that the acknowledge word and notices show only the operation's effect, and that the still-offered delivery is latched one cycle later. The end-of-interrupt followed by its resend cycle is a second collision window, judged by both ready signals being low while the resend notice appears.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        OP_SET_CPPR = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } ipc_op_e;

    typedef enum logic [1:0] {
        NTF_NONE   = 2'd0,
        NTF_REJECT = 2'd1,
        NTF_EOI    = 2'd2,
        NTF_RESEND = 2'd3
    } ipc_ntf_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESEND = 1'b1
    } ipc_state_e;

endpackage

// File: rtl/ipc_prio_cmp.sv
module ipc_prio_cmp #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand,
    input  logic [PRIO_W-1:0] limit,
    input  logic              has_pend,
    input  logic [PRIO_W-1:0] pend,
    output logic              wins
);
    // candidate must beat the running priority and any latched offer
    always_comb begin
        wins = (cand < limit) && (!has_pend || (cand < pend));
    end
endmodule

// File: rtl/ipc_ntf_reg.sv
module ipc_ntf_reg #(
    parameter int SRC_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  ipc_pkg::ipc_ntf_e   kind,
    input  logic [SRC_W-1:0]    src,
    output logic                valid_o,
    output logic [1:0]          kind_o,
    output logic [SRC_W-1:0]    src_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            kind_o  <= 2'd0;
            src_o   <= '0;
        end else begin
            valid_o <= fire;
            kind_o  <= fire ? kind : ipc_pkg::NTF_NONE;
            src_o   <= fire ? src : '0;
        end
    end

    AST_NTF_KIND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (kind_o != 2'd0)); // R9
endmodule

// File: rtl/ipc_core.sv
module ipc_core #(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [1:0]               op_code,
    input  logic [PRIO_W+SRC_W-1:0]  op_wdata,
    output logic                     op_ready,
    output logic                     rd_valid,
    output logic [PRIO_W+SRC_W-1:0]  rd_data,
    input  logic                     dlv_valid,
    input  logic [SRC_W-1:0]         dlv_src,
    input  logic [PRIO_W-1:0]        dlv_prio,
    output logic                     dlv_ready,
    output logic                     ntf_valid,
    output logic [1:0]               ntf_kind,
    output logic [SRC_W-1:0]         ntf_src,
    output logic                     irq_out,
    output logic [PRIO_W+SRC_W-1:0]  ack_word,
    output logic [PRIO_W-1:0]        ipi_prio
);
    import ipc_pkg::*;

    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    ipc_state_e        state_q, state_d;
    logic [PRIO_W-1:0] cppr_q, cppr_d;
    logic [SRC_W-1:0]  xisr_q, xisr_d;
    logic [PRIO_W-1:0] pend_q, pend_d;
    logic [PRIO_W-1:0] mfrr_q, mfrr_d;
    logic              irq_q, irq_d;
    logic              rdv_q, rdv_d;
    logic [WORD_W-1:0] rdd_q, rdd_d;

    logic              ntf_fire;
    ipc_ntf_e          ntf_k;
    logic [SRC_W-1:0]  ntf_s;

    ipc_op_e           op;
    logic              op_fire, dlv_fire, has_pend;
    logic              dlv_wins, ipi_wins;
    logic [PRIO_W-1:0] wr_prio, ipi_cand, ipi_limit;

    assign op        = ipc_op_e'(op_code);
    assign op_ready  = (state_q == ST_IDLE);
    assign dlv_ready = (state_q == ST_IDLE) && !op_valid;
    assign op_fire   = op_valid && op_ready;
    assign dlv_fire  = dlv_valid && dlv_ready;
    assign has_pend  = (xisr_q != '0);
    assign wr_prio   = op_wdata[PRIO_W-1:0];

    // IPI check limit: the current priority the operation leaves behind
    always_comb begin
        ipi_cand  = (op == OP_SET_IPI) ? wr_prio : mfrr_q;
        ipi_limit = cppr_q;
        if (op == OP_SET_CPPR) ipi_limit = wr_prio;
        if (op == OP_EOI)      ipi_limit = op_wdata[WORD_W-1:SRC_W];
    end

    ipc_prio_cmp #(.PRIO_W(PRIO_W)) u_cmp_dlv (
        .cand(dlv_prio), .limit(cppr_q), .has_pend(has_pend),
        .pend(pend_q), .wins(dlv_wins)
    );

    ipc_prio_cmp #(.PRIO_W(PRIO_W)) u_cmp_ipi (
        .cand(ipi_cand), .limit(ipi_limit), .has_pend(has_pend),
        .pend(pend_q), .wins(ipi_wins)
    );

    // next-state and notice selection
    always_comb begin
        state_d  = ST_IDLE;
        cppr_d   = cppr_q;
        xisr_d   = xisr_q;
        pend_d   = pend_q;
        mfrr_d   = mfrr_q;
        irq_d    = irq_q;
        rdv_d    = 1'b0;
        rdd_d    = rdd_q;
        ntf_fire = 1'b0;
        ntf_k    = NTF_NONE;
        ntf_s    = '0;
        unique case (state_q)
            ST_RESEND: begin
                ntf_fire = 1'b1;
                ntf_k    = NTF_RESEND;
            end
            ST_IDLE: begin
                if (op_fire) begin
                    unique case (op)
                        OP_SET_CPPR: begin
                            cppr_d = wr_prio;
                            if (wr_prio < cppr_q) begin
                                if (has_pend && (wr_prio <= pend_q)) begin
                                    xisr_d   = '0;
                                    pend_d   = PRIO_NONE;
                                    irq_d    = 1'b0;
                                    ntf_fire = 1'b1;
                                    ntf_k    = NTF_REJECT;
                                    ntf_s    = xisr_q;
                                end
                            end else if (!has_pend) begin
                                ntf_fire = 1'b1;
                                ntf_k    = NTF_RESEND;
                                if (ipi_wins) begin
                                    xisr_d = IPI_NUM;
                                    pend_d = mfrr_q;
                                    irq_d  = 1'b1;
                                end
                            end
                        end
                        OP_SET_IPI: begin
                            mfrr_d = wr_prio;
                            if (ipi_wins) begin
                                if (has_pend) begin
                                    ntf_fire = 1'b1;
                                    ntf_k    = NTF_REJECT;
                                    ntf_s    = xisr_q;
                                end
                                xisr_d = IPI_NUM;
                                pend_d = wr_prio;
                                irq_d  = 1'b1;
                            end
                        end
                        OP_ACCEPT: begin
                            rdv_d  = 1'b1;
                            rdd_d  = {cppr_q, xisr_q};
                            irq_d  = 1'b0;
                            cppr_d = pend_q;
                            xisr_d = '0;
                            pend_d = PRIO_NONE;
                        end
                        OP_EOI: begin
                            cppr_d   = op_wdata[WORD_W-1:SRC_W];
                            ntf_fire = 1'b1;
                            ntf_k    = NTF_EOI;
                            ntf_s    = op_wdata[SRC_W-1:0];
                            if (!has_pend) begin
                                state_d = ST_RESEND;
                                if (ipi_wins) begin
                                    xisr_d = IPI_NUM;
                                    pend_d = mfrr_q;
                                    irq_d  = 1'b1;
                                end
                            end
                        end
                    endcase
                end else if (dlv_fire) begin
                    ntf_k = NTF_REJECT;
                    if (dlv_wins) begin
                        ntf_fire = has_pend;
                        ntf_s    = xisr_q;
                        xisr_d   = dlv_src;
                        pend_d   = dlv_prio;
                        irq_d    = 1'b1;
                    end else begin
                        ntf_fire = 1'b1;
                        ntf_s    = dlv_src;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cppr_q  <= '0;
            xisr_q  <= '0;
            pend_q  <= PRIO_NONE;
            mfrr_q  <= PRIO_NONE;
            irq_q   <= 1'b0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            state_q <= state_d;
            cppr_q  <= cppr_d;
            xisr_q  <= xisr_d;
            pend_q  <= pend_d;
            mfrr_q  <= mfrr_d;
            irq_q   <= irq_d;
            rdv_q   <= rdv_d;
            rdd_q   <= rdd_d;
        end
    end

    ipc_ntf_reg #(.SRC_W(SRC_W)) u_ntf (
        .clk(clk), .rst_n(rst_n), .fire(ntf_fire), .kind(ntf_k), .src(ntf_s),
        .valid_o(ntf_valid), .kind_o(ntf_kind), .src_o(ntf_src)
    );

    assign irq_out  = irq_q;
    assign ack_word = {cppr_q, xisr_q};
    assign ipi_prio = mfrr_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;

    AST_IRQ_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (ack_word[SRC_W-1:0] != '0)); // R3
    AST_LOSER_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_fire && ((dlv_prio >= cppr_q) || (has_pend && (pend_q <= dlv_prio))))
        |=> ($stable(ack_word) && ntf_valid && (ntf_kind == 2'd1))); // R2
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (op_code == 2'd2))
        |=> (!irq_out && (ack_word[SRC_W-1:0] == '0) && rd_valid)); // R4
    AST_EOI_TO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (op_code == 2'd3) && !has_pend) |=> (state_q == ST_RESEND)); // R8
    AST_RESEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESEND) |=> (ntf_valid && (ntf_kind == 2'd3))); // R8
    AST_NO_READY_IN_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESEND) |-> (!op_ready && !dlv_ready)); // R10
endmodule

// File: tb/tb_ipc_core.sv
`timescale 1ns/1ps
module tb_ipc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] op_wdata = '0;
    logic        op_ready, rd_valid, dlv_ready, ntf_valid, irq_out;
    logic [31:0] rd_data, ack_word;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic [1:0]  ntf_kind;
    logic [23:0] ntf_src;
    logic [7:0]  ipi_prio;
    logic [31:0] ntf_word;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ipc_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_wdata(op_wdata), .op_ready(op_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
        .dlv_prio(dlv_prio), .dlv_ready(dlv_ready), .ntf_valid(ntf_valid),
        .ntf_kind(ntf_kind), .ntf_src(ntf_src), .irq_out(irq_out),
        .ack_word(ack_word), .ipi_prio(ipi_prio)
    );

    assign ntf_word = {5'b0, ntf_valid, ntf_kind, ntf_src};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nw(input logic [1:0] k, input logic [23:0] s);
        return {5'b0, (k != 2'd0), k, s};
    endfunction

    task automatic do_op(input logic [1:0] code, input logic [31:0] data);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_wdata = data;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_dlv(input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        dlv_valid = 1'b1; dlv_src = s; dlv_prio = p;
        @(negedge clk);
        dlv_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "ack", ack_word, 32'h0);
        chk("R1", "ipi", {24'b0, ipi_prio}, 32'hFF);
        chk("R1", "irq", {31'b0, irq_out}, 32'h0);
        chk("R1", "ntf", ntf_word, 32'h0);
        chk("R10", "ready", {30'b0, op_ready, dlv_ready}, 32'h3);
    endtask

    task automatic t_reject_rules;
        do_dlv(24'h10, 8'h05);               // cppr is 0: loses
        chk("R2", "ntf below cppr", ntf_word, nw(2'd1, 24'h10));
        chk("R2", "ack unchanged", ack_word, 32'h0);
        do_op(2'd0, 32'hFF);                 // raise, nothing latched
        chk("R6", "resend", ntf_word, nw(2'd3, 24'h0));
        chk("R6", "ack no ipi", ack_word, 32'hFF000000);
        do_dlv(24'h10, 8'h05);
        chk("R3", "latch", ack_word, 32'hFF000010);
        chk("R3", "irq", {31'b0, irq_out}, 32'h1);
        chk("R3", "no ntf", ntf_word, 32'h0);
        do_dlv(24'h20, 8'h05);               // equal to pending: loses
        chk("R2", "ntf tie", ntf_word, nw(2'd1, 24'h20));
        chk("R2", "ack kept", ack_word, 32'hFF000010);
        do_dlv(24'h30, 8'h03);               // displaces 0x10
        chk("R3", "displaced reject", ntf_word, nw(2'd1, 24'h10));
        chk("R3", "new latch", ack_word, 32'hFF000030);
    endtask

    task automatic t_ipi;
        do_op(2'd1, 32'h04);                 // pending 3 <= 4: kept
        chk("R7", "ipi stored", {24'b0, ipi_prio}, 32'h04);
        chk("R7", "ack kept", ack_word, 32'hFF000030);
        chk("R7", "no ntf", ntf_word, 32'h0);
        do_op(2'd1, 32'h01);                 // beats pending 3
        chk("R7", "reject old", ntf_word, nw(2'd1, 24'h30));
        chk("R7", "ipi latched", ack_word, 32'hFF000002);
        chk("R7", "irq", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_accept_eoi;
        do_op(2'd2, 32'h0);
        chk("R4", "rd_valid", {31'b0, rd_valid}, 32'h1);
        chk("R4", "rd_data", rd_data, 32'hFF000002);
        chk("R4", "ack after", ack_word, 32'h01000000);
        chk("R4", "irq low", {31'b0, irq_out}, 32'h0);
        do_op(2'd3, 32'hFF000002);           // ipi 1 < FF re-latches
        chk("R8", "eoi ntf", ntf_word, nw(2'd2, 24'h2));
        chk("R8", "ipi relatch", ack_word, 32'hFF000002);
        chk("R10", "blocked", {30'b0, op_ready, dlv_ready}, 32'h0);
        @(negedge clk);
        chk("R8", "resend next", ntf_word, nw(2'd3, 24'h0));
        chk("R9", "pulse gone", {31'b0, rd_valid}, 32'h0);
        do_op(2'd1, 32'hFF);                 // not below cppr: store only
        chk("R7", "store only", ack_word, 32'hFF000002);
        chk("R7", "ipi ff", {24'b0, ipi_prio}, 32'hFF);
    endtask

    task automatic t_lower_cppr;
        do_op(2'd0, 32'h02);                 // pending 1 more favored: kept
        chk("R5", "kept", ack_word, 32'h02000002);
        chk("R5", "no ntf", ntf_word, 32'h0);
        do_op(2'd0, 32'h01);                 // 1 <= 1: bounced
        chk("R5", "bounce ntf", ntf_word, nw(2'd1, 24'h2));
        chk("R5", "ack cleared", ack_word, 32'h01000000);
        chk("R5", "irq low", {31'b0, irq_out}, 32'h0);
        do_dlv(24'h40, 8'h00);
        chk("R3", "latch p0", ack_word, 32'h01000040);
        do_op(2'd2, 32'h0);
        chk("R4", "rd 40", rd_data, 32'h01000040);
        chk("R4", "cppr from pend", ack_word, 32'h00000000);
        do_op(2'd3, 32'hFF000040);
        chk("R8", "eoi 40", ntf_word, nw(2'd2, 24'h40));
        chk("R8", "no ipi", ack_word, 32'hFF000000);
        @(negedge clk);
        chk("R8", "resend 40", ntf_word, nw(2'd3, 24'h0));
    endtask

    task automatic t_collide;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd1; op_wdata = 32'hFF;
        dlv_valid = 1'b1; dlv_src = 24'h50; dlv_prio = 8'h02;
        #1;
        chk("R10", "dlv held off", {31'b0, dlv_ready}, 32'h0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", "op only", ack_word, 32'hFF000000);
        chk("R10", "no ntf", ntf_word, 32'h0);
        #1;
        chk("R10", "dlv ready", {31'b0, dlv_ready}, 32'h1);
        @(negedge clk);
        dlv_valid = 1'b0;
        chk("R10", "dlv taken", ack_word, 32'hFF000050);
        repeat (3) @(negedge clk);
        chk("R11", "poll stable", ack_word, 32'hFF000050);
        chk("R11", "ipi stable", {24'b0, ipi_prio}, 32'hFF);
        chk("R11", "irq stable", {31'b0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject_rules();
        t_ipi();
        t_accept_eoi();
        t_lower_cppr();
        t_collide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule